// File: doc/BRIEF.md
# Two-Pin Oscilloscope Probe Serializer

This block lets an oscilloscope show a wide internal signal vector while using only two spare output pins. At the start of each frame it copies a 30-bit parallel word into a private holding register. It then sends that word one bit per slot on a data pin, most significant bit first. A frame has 32 slots. Each slot lasts a fixed number of system clock cycles, set by a parameter, which gives a slow bit rate of about 1 MHz. A second pin is high only during the first slot, so the scope can trigger cleanly on every frame.

Two modes are available. In free-running mode, frames follow each other with no gap, and each new frame captures the current value of the input vector. In triggered mode, the block stays quiet until a one-cycle start request arrives. It then sends exactly one frame. A request that arrives during a frame is held and served as soon as that frame ends. A busy output shows when a frame is on the pins.

Top module: `scope_vector_probe`

## Requirements
- R1: While the synchronous active-high reset is asserted, and after it is released, the data pin, the marker pin and busy are all low until a frame starts.
- R2: A frame is 32 slots, numbered 0 to 31. In slot k, for k from 0 to 29, the data pin carries bit (29 − k) of the captured word, so the word goes out most significant bit first.
- R3: In slots 30 and 31, the data pin is low.
- R4: The marker pin is high during slot 0 of every frame and low in every other slot.
- R5: Each slot lasts exactly DIV clock cycles. The pins change only on bit-enable cycles and hold their value in between.
- R6: The word sent in a frame is the input value present when the frame started. Later changes to the input during the frame do not affect that frame.
- R7: When the free-run input is high, frames follow back to back: slot 31 of one frame is followed directly by slot 0 of the next, and each frame captures the input again.
- R8: When the free-run input is low and the block is idle, a one-cycle start request makes slot 0 appear within DIV cycles. Exactly one frame is then sent, after which the block goes idle.
- R9: A start request that arrives during a frame is held. The next frame then begins directly after slot 31 of the current one.
- R10: In triggered mode with no pending request, the block is idle and both pins and busy stay low.
- R11: Busy is high during every slot of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| free_run | input | 1 | 1: frames repeat back to back; 0: one frame per start request |
| start_req | input | 1 | One-cycle request to send a frame (triggered mode) |
| probe_in | input | PAYLOAD_W | Parallel debug word to be shown |
| ser_data | output | 1 | Serial data pin |
| ser_mark | output | 1 | Frame marker pin, high during slot 0 |
| busy | output | 1 | High while a frame is being sent |

## Verification
The hardest case to reach from the ports is a start request that lands in the middle of a frame, together with an input word that changes during that same frame. To create it, the bench watches the marker pin, counts slots, and then drives a new word and a request pulse from inside the slot loop at a chosen slot. It then checks two things: the current frame still carries the old word, and the next frame begins immediately with the new word. A walking-one sweep over all 30 bit positions catches misordered or dropped bits. Sampling every clock cycle of every slot confirms that the pins change only on the bit enable.

// File: rtl/scope_ser_pkg.sv
package scope_ser_pkg;

    // Frame phase of the serializer controller.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SEND = 1'b1
    } phase_e;

    // Width of a counter that must hold values 0 .. n-1 (at least one bit).
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/scope_rate_tick.sv
module scope_rate_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    import scope_ser_pkg::*;

    localparam int CNT_W = cnt_width(DIV);

    generate
        if (DIV > 1) begin : g_div
            typedef struct packed {
                logic [CNT_W-1:0] cnt;
            } st_t;

            st_t cur_q, nxt_d;

            always_comb begin
                nxt_d = cur_q;
                if (cur_q.cnt == CNT_W'(DIV - 1)) begin
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) cur_q <= '0;
                else     cur_q <= nxt_d;
            end

            assign tick = (cur_q.cnt == CNT_W'(DIV - 1));

            // R5: two enables are never on adjacent cycles when DIV > 1
            a_r5_tick_spacing: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end else begin : g_full
            assign tick = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/scope_frame_ctrl.sv
module scope_frame_ctrl #(
    parameter int SLOTS = 32
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     tick,
    input  logic                                     free_run,
    input  logic                                     start_req,
    output logic                                     load,
    output logic                                     step,
    output logic                                     stop,
    output logic                                     busy,
    output logic [scope_ser_pkg::cnt_width(SLOTS)-1:0] slot
);
    import scope_ser_pkg::*;

    localparam int SLOT_W = cnt_width(SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [SLOT_W-1:0] slot;
        logic              pending;
    } st_t;

    st_t  cur_q, nxt_d;
    logic req_any;
    logic want_frame;

    always_comb begin
        nxt_d      = cur_q;
        load       = 1'b0;
        step       = 1'b0;
        stop       = 1'b0;
        req_any    = cur_q.pending | start_req;
        want_frame = free_run | req_any;
        nxt_d.pending = req_any;

        if (tick) begin
            if (cur_q.phase == PH_IDLE) begin
                if (want_frame) begin
                    load          = 1'b1;
                    nxt_d.phase   = PH_SEND;
                    nxt_d.slot    = '0;
                    nxt_d.pending = 1'b0;
                end
            end else if (cur_q.slot == LAST_SLOT) begin
                if (want_frame) begin
                    load          = 1'b1;
                    nxt_d.slot    = '0;
                    nxt_d.pending = 1'b0;
                end else begin
                    stop        = 1'b1;
                    nxt_d.phase = PH_IDLE;
                    nxt_d.slot  = '0;
                end
            end else begin
                step       = 1'b1;
                nxt_d.slot = cur_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.phase   <= PH_IDLE;
            cur_q.slot    <= '0;
            cur_q.pending <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy = (cur_q.phase == PH_SEND);
    assign slot = cur_q.slot;

    // R11: a frame never ends before its last slot
    a_r11_busy_until_last: assert property (@(posedge clk) disable iff (rst)
        (busy && slot != LAST_SLOT) |=> busy);

    // R9: a request seen during a frame is not lost before the frame ends
    a_r9_request_kept: assert property (@(posedge clk) disable iff (rst)
        (busy && start_req && !(tick && slot == LAST_SLOT)) |=> (cur_q.pending || load));

endmodule

// File: rtl/scope_shift_out.sv
module scope_shift_out #(
    parameter int PAYLOAD_W = 30
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 step,
    input  logic                 stop,
    input  logic [PAYLOAD_W-1:0] probe_in,
    output logic                 ser_data,
    output logic                 ser_mark
);
    typedef struct packed {
        logic [PAYLOAD_W-1:0] shadow;
        logic                 data;
        logic                 mark;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.shadow = probe_in;
            nxt_d.data   = probe_in[PAYLOAD_W-1];
            nxt_d.mark   = 1'b1;
        end else if (step) begin
            nxt_d.shadow = cur_q.shadow << 1;
            nxt_d.data   = cur_q.shadow[PAYLOAD_W-2];
            nxt_d.mark   = 1'b0;
        end else if (stop) begin
            nxt_d.shadow = '0;
            nxt_d.data   = 1'b0;
            nxt_d.mark   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign ser_data = cur_q.data;
    assign ser_mark = cur_q.mark;

    // R6: the captured word only moves when the controller steps or reloads it
    a_r6_shadow_frozen: assert property (@(posedge clk) disable iff (rst)
        !(load || step || stop) |=> $stable(cur_q.shadow));

endmodule

// File: rtl/scope_vector_probe.sv
module scope_vector_probe #(
    parameter int PAYLOAD_W = 30,
    parameter int SLOTS     = 32,
    parameter int DIV       = 50
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 free_run,
    input  logic                 start_req,
    input  logic [PAYLOAD_W-1:0] probe_in,
    output logic                 ser_data,
    output logic                 ser_mark,
    output logic                 busy
);
    import scope_ser_pkg::*;

    localparam int SLOT_W = cnt_width(SLOTS);

    logic              tick;
    logic              load;
    logic              step;
    logic              stop;
    logic [SLOT_W-1:0] slot;

    scope_rate_tick #(.DIV(DIV)) rate_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    scope_frame_ctrl #(.SLOTS(SLOTS)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .free_run  (free_run),
        .start_req (start_req),
        .load      (load),
        .step      (step),
        .stop      (stop),
        .busy      (busy),
        .slot      (slot)
    );

    scope_shift_out #(.PAYLOAD_W(PAYLOAD_W)) shift_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .stop     (stop),
        .probe_in (probe_in),
        .ser_data (ser_data),
        .ser_mark (ser_mark)
    );

    // R3: padding slots keep the data pin low
    a_r3_pad_low: assert property (@(posedge clk) disable iff (rst)
        (busy && int'(slot) >= PAYLOAD_W) |-> !ser_data);

    // R4: marker appears only in the first slot of a frame
    a_r4_mark_slot0: assert property (@(posedge clk) disable iff (rst)
        ser_mark |-> (busy && slot == '0));

    // R10: an idle block keeps both pins quiet
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_data && !ser_mark));

    // R5: pins hold between bit enables
    a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> ($stable(ser_data) && $stable(ser_mark) && $stable(busy)));

endmodule

// File: tb/scope_vector_probe_tb.sv
module scope_vector_probe_tb_top;

    localparam int W      = 30;
    localparam int SL     = 32;
    localparam int DIV    = 4;
    localparam int CLK_NS = 10;
    localparam int MID    = 11;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         free_run = 1'b0;
    logic         start_req = 1'b0;
    logic [W-1:0] probe_in = '0;
    logic         ser_data;
    logic         ser_mark;
    logic         busy;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    scope_vector_probe #(.PAYLOAD_W(W), .SLOTS(SL), .DIV(DIV)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .free_run  (free_run),
        .start_req (start_req),
        .probe_in  (probe_in),
        .ser_data  (ser_data),
        .ser_mark  (ser_mark),
        .busy      (busy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_start();
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    // Wait up to limit negedges for the marker; report R8-style latency.
    task automatic wait_mark(input int limit, input string req);
        bit got = 1'b0;
        for (int n = 0; n < limit; n++) begin
            if (ser_mark) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
        check(got, req, 32'(got), 32'd1);
    endtask

    // Entered at the first negedge of slot 0; leaves at the first negedge after slot 31.
    task automatic check_frame(input logic [W-1:0] exp, input logic [W-1:0] new_probe,
                               input bit req_mid);
        for (int k = 0; k < SL; k++) begin
            for (int j = 0; j < DIV; j++) begin
                logic expd;
                expd = (k < W) ? exp[W-1-k] : 1'b0;
                if (j > 0)
                    check(ser_data == expd, "R5 hold", 32'(ser_data), 32'(expd));
                else if (k < W)
                    check(ser_data == expd, "R2 bit order", 32'(ser_data), 32'(expd));
                else
                    check(ser_data == expd, "R3 padding", 32'(ser_data), 32'(expd));
                check(ser_mark == (k == 0), "R4 marker", 32'(ser_mark), 32'(k == 0));
                check(busy == 1'b1, "R11 busy", 32'(busy), 32'd1);
                if (k == MID && j == 0) begin
                    probe_in = new_probe;
                    if (req_mid) start_req = 1'b1;
                end
                @(negedge clk);
                start_req = 1'b0;
            end
        end
    endtask

    task automatic check_idle_after(input string req);
        check(!busy && !ser_data && !ser_mark, req, {29'd0, busy, ser_data, ser_mark}, 32'd0);
    endtask

    task automatic one_shot(input logic [W-1:0] pat);
        probe_in = pat;
        pulse_start();
        wait_mark(DIV + 1, "R8 start latency");
        check_frame(pat, ~pat, 1'b0);
        check_idle_after("R8 single frame");
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bad;
        logic [W-1:0] fr [5];

        // R1: reset state
        repeat (5) @(negedge clk);
        check(!ser_data && !ser_mark && !busy, "R1 in reset",
              {29'd0, busy, ser_data, ser_mark}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!ser_data && !ser_mark && !busy, "R1 after reset",
              {29'd0, busy, ser_data, ser_mark}, 32'd0);

        // R10: quiet while idle in triggered mode, even with input activity
        bad = 0;
        for (int c = 0; c < 3 * SL * DIV; c++) begin
            probe_in = W'(c * 32'h0137_5A1D);
            @(negedge clk);
            if (busy || ser_data || ser_mark) bad++;
        end
        check(bad == 0, "R10 idle quiet", 32'(bad), 32'd0);

        // R6 + R8: single frame, input changed mid-frame
        probe_in = 30'h2F0F_1234;
        pulse_start();
        wait_mark(DIV + 1, "R8 start latency");
        check_frame(30'h2F0F_1234, 30'h0123_4567, 1'b0);
        check_idle_after("R8 single frame");
        bad = 0;
        for (int c = 0; c < 2 * SL * DIV; c++) begin
            @(negedge clk);
            if (busy || ser_data || ser_mark) bad++;
        end
        check(bad == 0, "R10 idle after frame", 32'(bad), 32'd0);

        // R9: request during a frame, served back to back with new word
        probe_in = 30'h1555_AAAA;
        pulse_start();
        wait_mark(DIV + 1, "R8 start latency");
        check_frame(30'h1555_AAAA, 30'h3C3C_0F0F, 1'b1);
        check(ser_mark == 1'b1, "R9 back-to-back", 32'(ser_mark), 32'd1);
        check_frame(30'h3C3C_0F0F, 30'h3C3C_0F0F, 1'b0);
        check_idle_after("R9 then idle");

        // R2/R3: walking one across every bit, plus dense patterns
        for (int i = 0; i < W; i++) one_shot(W'(1) << i);
        one_shot('1);
        one_shot(30'h2AAA_AAAA);
        one_shot(30'h1555_5555);

        // R7: free-running frames, new word each frame
        for (int f = 0; f < 5; f++) fr[f] = W'(32'h0BAD_F00D * (f + 3));
        probe_in = fr[0];
        free_run = 1'b1;
        @(negedge clk);
        wait_mark(DIV + 1, "R7 free-run start");
        for (int f = 0; f < 4; f++) begin
            check_frame(fr[f], fr[f+1], 1'b0);
            check(ser_mark == 1'b1, "R7 back-to-back", 32'(ser_mark), 32'd1);
        end
        free_run = 1'b0;
        check_frame(fr[4], fr[4], 1'b0);
        check_idle_after("R7 stop after free-run");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule